// File: doc/BRIEF.md
# LIN Slave Status Tracker

This block holds the status flags of a LIN slave controller and drives its interrupt request. A frame engine beside it reports events as single-cycle strobes: a break that opens a frame, reception of the identifier, successful completion of a frame, a detected error, and a wake-up that is seen or sent. It also reports bus activity as a level. The host drives its own command strobes: stop, data acknowledge, clear-interrupt and clear-error. It also drives a sleep level that masks the idle timeout.

The block tracks whether a frame is open. A break that arrives while a frame is still open marks the frame as aborted. A received identifier raises a data request that stays pending until the host acknowledges it. A bus that stays quiet for a programmable number of clock cycles raises an idle timeout. The status byte is read directly. Every flag updates on the clock edge that samples its cause, so a flag shows one cycle after its strobe.

Top module: `lin_slave_status`

## Requirements
- R1: During and straight after reset, the status byte is 0x00 and irq is 0.
- R2: Bit 7 (activity) equals the bus_active input from the previous cycle.
- R3: Bit 6 (idle timeout) sets after IDLE_TICKS consecutive quiet cycles with sleep_mode low. A quiet cycle has bus_active low and no event strobe. Any non-quiet cycle clears the bit and restarts the count. While sleep_mode is high, the count is held at zero.
- R4: Bit 5 (abort) sets on host_stop. It also sets on ev_break while a frame is open. A frame opens on ev_break and closes on ev_frame_ok, ev_error or host_stop. The bit clears on ev_break when no frame is open.
- R5: Bit 4 (data request) sets on ev_ident and clears on host_data_ack.
- R6: Bit 3 (interrupt) sets whenever any of bits 6, 4, 2, 1 or 0 goes from 0 to 1. It clears on host_clr_int.
- R7: Bit 2 (error) sets on ev_error and stays set until host_clr_err.
- R8: Bit 1 (wake-up) sets on ev_wake and clears on ev_break.
- R9: Bit 0 (done) sets on ev_frame_ok and clears on ev_break.
- R10: When a set cause and a clear cause for the same flag arrive in one cycle, the flag ends up set.
- R11: The irq output always equals bit 3 of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_active | input | 1 | Level from the frame engine: activity on the bus |
| ev_break | input | 1 | Strobe: break detected |
| ev_ident | input | 1 | Strobe: identifier received |
| ev_frame_ok | input | 1 | Strobe: frame completed without error |
| ev_error | input | 1 | Strobe: communication error |
| ev_wake | input | 1 | Strobe: wake-up seen or being sent |
| sleep_mode | input | 1 | Host level: bus is asleep, idle timeout masked |
| host_stop | input | 1 | Host strobe: stop the current frame |
| host_data_ack | input | 1 | Host strobe: data request handled |
| host_clr_int | input | 1 | Host strobe: clear the interrupt flag |
| host_clr_err | input | 1 | Host strobe: clear the error flag |
| status_byte | output | 8 | Status flags, bit 7 down to 0: activity, idle timeout, abort, data request, interrupt, error, wake-up, done |
| irq | output | 1 | Interrupt request |

## Verification
A wrong frame-open state has no bit of its own. It shows only at the next break, which then sets or clears the abort flag wrongly in the following cycle. A wrong idle counter shows as the timeout bit rising early or late, or rising during sleep. A missed rising-edge detection leaves irq low one cycle after a flag rises. Because every output is compared with a reference model on every cycle, each such fault shows up within one cycle of the stimulus that exposes it.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;

    // Flags held in the top level, ordered as they appear in the status byte
    typedef struct packed {
        logic active;
        logic idle_to;
        logic irq_f;
        logic err;
        logic wake;
    } top_flags_t;

    // Frame handshake state
    typedef struct packed {
        logic in_frame;
        logic abort_f;
        logic dreq;
        logic done;
    } frame_state_t;

    function automatic logic [7:0] pack_status(input top_flags_t f, input frame_state_t s);
        return {f.active, f.idle_to, s.abort_f, s.dreq, f.irq_f, f.err, f.wake, s.done};
    endfunction

endpackage

// File: rtl/lin_idle_timer.sv
module lin_idle_timer #(
    parameter int unsigned IDLE_TICKS = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet,
    input  logic sleep_mode,
    output logic fire
);
    localparam int unsigned CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_TICKS);
    localparam logic [CW-1:0] LAST  = CW'(IDLE_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (!quiet || sleep_mode) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
            fire  = (cnt_q == LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lin_frame_tracker.sv
module lin_frame_tracker
    import lin_stat_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_break,
    input  logic         ev_ident,
    input  logic         ev_frame_ok,
    input  logic         ev_error,
    input  logic         host_stop,
    input  logic         host_data_ack,
    output frame_state_t st,
    output logic         dreq_rise,
    output logic         done_rise
);
    frame_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // frame open/close; a break always opens a new frame
        if (ev_frame_ok || ev_error || host_stop) st_d.in_frame = 1'b0;
        if (ev_break)                             st_d.in_frame = 1'b1;
        // abort: break mid-frame sets, clean break clears, stop sets (wins)
        if (ev_break)  st_d.abort_f = st_q.in_frame;
        if (host_stop) st_d.abort_f = 1'b1;
        // data request handshake
        if (host_data_ack) st_d.dreq = 1'b0;
        if (ev_ident)      st_d.dreq = 1'b1;
        // completion
        if (ev_break)    st_d.done = 1'b0;
        if (ev_frame_ok) st_d.done = 1'b1;
        dreq_rise = st_d.dreq & ~st_q.dreq;
        done_rise = st_d.done & ~st_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/lin_slave_status.sv
module lin_slave_status
    import lin_stat_pkg::*;
#(
    parameter int unsigned IDLE_TICKS = 200_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_active,
    input  logic       ev_break,
    input  logic       ev_ident,
    input  logic       ev_frame_ok,
    input  logic       ev_error,
    input  logic       ev_wake,
    input  logic       sleep_mode,
    input  logic       host_stop,
    input  logic       host_data_ack,
    input  logic       host_clr_int,
    input  logic       host_clr_err,
    output logic [7:0] status_byte,
    output logic       irq
);
    top_flags_t   fl_d, fl_q;
    frame_state_t fr_st;
    logic         quiet, idle_fire, dreq_rise, done_rise, new_evt;

    assign quiet = !bus_active && !(ev_break || ev_ident || ev_frame_ok || ev_error || ev_wake);

    lin_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .quiet      (quiet),
        .sleep_mode (sleep_mode),
        .fire       (idle_fire)
    );

    lin_frame_tracker u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_break      (ev_break),
        .ev_ident      (ev_ident),
        .ev_frame_ok   (ev_frame_ok),
        .ev_error      (ev_error),
        .host_stop     (host_stop),
        .host_data_ack (host_data_ack),
        .st            (fr_st),
        .dreq_rise     (dreq_rise),
        .done_rise     (done_rise)
    );

    always_comb begin
        fl_d        = fl_q;
        fl_d.active = bus_active;
        if (!quiet)      fl_d.idle_to = 1'b0;
        if (idle_fire)   fl_d.idle_to = 1'b1;
        if (host_clr_err) fl_d.err    = 1'b0;
        if (ev_error)     fl_d.err    = 1'b1;
        if (ev_break)     fl_d.wake   = 1'b0;
        if (ev_wake)      fl_d.wake   = 1'b1;
        new_evt = (fl_d.idle_to & ~fl_q.idle_to) | (fl_d.err & ~fl_q.err)
                | (fl_d.wake & ~fl_q.wake) | dreq_rise | done_rise;
        if (host_clr_int) fl_d.irq_f = 1'b0;
        if (new_evt)      fl_d.irq_f = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign status_byte = pack_status(fl_q, fr_st);
    assign irq         = fl_q.irq_f;
endmodule

// File: rtl/lin_status_chk.sv
module lin_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_active,
    input logic       ev_break,
    input logic       ev_ident,
    input logic       ev_frame_ok,
    input logic       ev_error,
    input logic       host_stop,
    input logic       host_clr_err,
    input logic [7:0] status_byte,
    input logic       irq
);
    AST_ACTIVE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |=> status_byte[7]); // R2
    AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        host_stop |=> status_byte[5]); // R4
    AST_DREQ_ON_ID: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ident |=> status_byte[4]); // R5
    AST_ERR_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_error && !status_byte[2]) |=> (status_byte[3] && irq)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[2] && !host_clr_err) |=> status_byte[2]); // R7
    AST_DONE_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_ok |=> status_byte[0]); // R9
    AST_DONE_CLR_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_break && !ev_frame_ok) |=> !status_byte[0]); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_error && host_clr_err) |=> status_byte[2]); // R10
endmodule

bind lin_slave_status lin_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_active   (bus_active),
    .ev_break     (ev_break),
    .ev_ident     (ev_ident),
    .ev_frame_ok  (ev_frame_ok),
    .ev_error     (ev_error),
    .host_stop    (host_stop),
    .host_clr_err (host_clr_err),
    .status_byte  (status_byte),
    .irq          (irq)
);

// File: tb/tb_lin_slave_status.sv
`timescale 1ns/1ps
module tb_lin_slave_status;
    localparam int N_IDLE = 20;

    logic clk = 0;
    logic rst_n = 0;
    logic bus_active = 0, ev_break = 0, ev_ident = 0, ev_frame_ok = 0, ev_error = 0, ev_wake = 0;
    logic sleep_mode = 0, host_stop = 0, host_data_ack = 0, host_clr_int = 0, host_clr_err = 0;
    logic [7:0] status_byte;
    logic irq;

    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    lin_slave_status #(.IDLE_TICKS(N_IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .ev_break(ev_break),
        .ev_ident(ev_ident), .ev_frame_ok(ev_frame_ok), .ev_error(ev_error),
        .ev_wake(ev_wake), .sleep_mode(sleep_mode), .host_stop(host_stop),
        .host_data_ack(host_data_ack), .host_clr_int(host_clr_int),
        .host_clr_err(host_clr_err), .status_byte(status_byte), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit m[8];          // index = status bit position
    bit m_open;
    int m_quiet;

    always @(posedge clk) begin
        bit old[8];
        bit any_evt, rise;
        if (!rst_n) begin
            foreach (m[i]) m[i] = 0;
            m_open = 0; m_quiet = 0;
        end else begin
            old = m;
            any_evt = ev_break | ev_ident | ev_frame_ok | ev_error | ev_wake;
            m[7] = bus_active;
            if (bus_active || any_evt) begin
                m_quiet = 0; m[6] = 0;
            end else if (sleep_mode) begin
                m_quiet = 0;
            end else if (m_quiet < N_IDLE) begin
                m_quiet++;
                if (m_quiet == N_IDLE) m[6] = 1;
            end
            if (host_stop) m[5] = 1;
            else if (ev_break) m[5] = m_open;
            if (ev_break) m_open = 1;
            else if (ev_frame_ok || ev_error || host_stop) m_open = 0;
            m[4] = ev_ident ? 1 : (host_data_ack ? 0 : m[4]);
            m[2] = ev_error ? 1 : (host_clr_err ? 0 : m[2]);
            m[1] = ev_wake ? 1 : (ev_break ? 0 : m[1]);
            m[0] = ev_frame_ok ? 1 : (ev_break ? 0 : m[0]);
            rise = 0;
            foreach (m[i]) if (i != 7 && i != 5 && i != 3 && m[i] && !old[i]) rise = 1;
            if (rise) m[3] = 1;
            else if (host_clr_int) m[3] = 0;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, one check per requirement bit
    string tags[8] = '{"R9", "R8", "R7", "R6", "R5", "R4", "R3", "R2"};
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 8; i++) chk(tags[i], {7'd0, status_byte[i]}, {7'd0, m[i]});
            chk("R11", {7'd0, irq}, {7'd0, m[3]});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_strobes();
        ev_break = 0; ev_ident = 0; ev_frame_ok = 0; ev_error = 0; ev_wake = 0;
        host_stop = 0; host_data_ack = 0; host_clr_int = 0; host_clr_err = 0;
    endtask

    initial begin
        tick(3);
        chk("R1 status in reset", status_byte, 8'h00);
        chk("R1 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1;
        tick(1);
        chk("R1 status after reset", status_byte, 8'h00);

        // R2 activity level
        bus_active = 1; tick(1);
        chk("R2 active set", status_byte & 8'h80, 8'h80);
        tick(3); bus_active = 0; tick(1);
        chk("R2 active clear", status_byte & 8'h80, 8'h00);

        // normal frame: break, ident, ack, complete
        ev_break = 1; tick(1); clear_strobes();
        chk("R4 clean break no abort", status_byte & 8'h20, 8'h00);
        ev_ident = 1; tick(1); clear_strobes();
        chk("R5 dreq set", status_byte & 8'h10, 8'h10);
        chk("R6 irq on dreq", {7'd0, irq}, 8'h01);
        host_data_ack = 1; host_clr_int = 1; tick(1); clear_strobes();
        chk("R5 dreq cleared", status_byte & 8'h18, 8'h00);
        ev_frame_ok = 1; tick(1); clear_strobes();
        chk("R9 done set + R6 int", status_byte & 8'h09, 8'h09);

        // break mid-frame -> abort, then clean break clears abort
        host_clr_int = 1; ev_break = 1; tick(1); clear_strobes();
        chk("R9 done cleared by break", status_byte & 8'h01, 8'h00);
        ev_break = 1; tick(1); clear_strobes();
        chk("R4 abort on mid-frame break", status_byte & 8'h20, 8'h20);
        ev_frame_ok = 1; tick(1); clear_strobes();
        ev_break = 1; tick(1); clear_strobes();
        chk("R4 abort cleared by clean break", status_byte & 8'h20, 8'h00);
        host_stop = 1; tick(1); clear_strobes();
        chk("R4 abort on stop", status_byte & 8'h20, 8'h20);
        ev_break = 1; tick(1); clear_strobes();
        chk("R4 stop closed frame", status_byte & 8'h20, 8'h00);

        // error handling and R10 same-cycle set/clear
        host_clr_int = 1; tick(1); clear_strobes();
        ev_error = 1; tick(1); clear_strobes();
        chk("R7 error set, R6 int", status_byte & 8'h0C, 8'h0C);
        tick(3);
        chk("R7 error sticky", status_byte & 8'h04, 8'h04);
        host_clr_err = 1; tick(1); clear_strobes();
        chk("R7 error cleared", status_byte & 8'h04, 8'h00);
        ev_error = 1; host_clr_err = 1; tick(1); clear_strobes();
        chk("R10 error set wins", status_byte & 8'h04, 8'h04);
        host_clr_int = 1; ev_ident = 1; tick(1); clear_strobes();
        chk("R10 int set wins", {7'd0, irq}, 8'h01);
        ev_ident = 1; host_data_ack = 1; tick(1); clear_strobes();
        chk("R10 dreq set wins", status_byte & 8'h10, 8'h10);

        // wake-up
        host_clr_int = 1; host_clr_err = 1; host_data_ack = 1; tick(1); clear_strobes();
        chk("R6 int cleared", {7'd0, irq}, 8'h00);
        ev_wake = 1; tick(1); clear_strobes();
        chk("R8 wake set + R6 int", status_byte & 8'h0A, 8'h0A);
        ev_break = 1; tick(1); clear_strobes();
        chk("R8 wake cleared by break", status_byte & 8'h02, 8'h00);

        // idle timeout: N_IDLE quiet cycles after the break strobe above
        host_clr_int = 1; tick(1); clear_strobes();
        tick(N_IDLE - 2);
        chk("R3 not yet timed out", status_byte & 8'h40, 8'h00);
        tick(1);
        chk("R3 timeout set + R6 int", status_byte & 8'h48, 8'h48);
        bus_active = 1; tick(1); bus_active = 0;
        chk("R3 cleared by activity", status_byte & 8'h40, 8'h00);
        sleep_mode = 1; tick(3 * N_IDLE);
        chk("R3 masked by sleep", status_byte & 8'h40, 8'h00);
        sleep_mode = 0; tick(N_IDLE + 2);
        chk("R3 timeout after sleep ends", status_byte & 8'h40, 8'h40);

        // mixed burst for the per-cycle model comparison
        for (int k = 0; k < 300; k++) begin
            bus_active = k[2]; ev_break = (k % 7 == 0); ev_ident = (k % 5 == 1);
            ev_frame_ok = (k % 11 == 3); ev_error = (k % 13 == 4); ev_wake = (k % 17 == 6);
            host_stop = (k % 19 == 8); host_data_ack = (k % 3 == 0); host_clr_int = (k % 4 == 2);
            host_clr_err = (k % 6 == 5); sleep_mode = (k > 200);
            tick(1);
        end
        clear_strobes(); bus_active = 0; sleep_mode = 0;
        tick(N_IDLE + 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule